// File: doc/BRIEF.md
# Software Store Unlock Sequence Detector

This block watches the access stream of a memory that is backed by nonvolatile cells and turns a fixed, ordered run of six read addresses into a request to save the memory to its nonvolatile copy. Each access is presented as a one-cycle strobe that carries a read/write flag and a 15-bit address. Matching reads advance an internal step position. A read at the wrong point, or any write, throws the partial match away.

When the sixth read lands in order, the block raises a one-cycle request towards the store controller. At the same time it raises an I/O disable. The disable stays high until the controller reports that the save has finished. The controller does this only after it has both erased and reprogrammed the nonvolatile array. While the disable is high, every access strobe is ignored.

Top module: `swst_seq_detect`

## Requirements
- R1: After reset, `store_req` and `io_disable` are 0 and the step position is at the start, so reads of the last five unlock addresses alone produce no request.
- R2: Accepted reads (`acc_valid`=1, `acc_write`=0) of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0, in that order, raise `store_req` in the cycle after the edge that samples the sixth read.
- R3: `store_req` is high for exactly one cycle per completed sequence, and the step position returns to the start afterwards.
- R4: An accepted read of an address other than the one expected next aborts the match. Finishing the remaining steps afterwards gives no request.
- R5: An accepted write (`acc_write`=1) aborts the match at any step, even when its address is the next expected one.
- R6: An accepted read of 0x0E38 that does not match the expected step counts as step one of a fresh match, so the next five addresses complete a sequence.
- R7: `io_disable` rises together with `store_req`. It stays high until `store_done` is sampled high, and it falls in the cycle after that edge.
- R8: While `io_disable` is high, access strobes are ignored: a full sequence gives no request and leaves the step position at the start.
- R9: `store_done` sampled while `io_disable` is low has no effect on the outputs or on a match in progress.
- R10: Cycles with `acc_valid`=0 between steps leave the step position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | One-cycle strobe marking an access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 15 | Access address |
| store_done | input | 1 | Store controller reports that erase and program have finished |
| store_req | output | 1 | One-cycle software store request |
| io_disable | output | 1 | High while a store is in progress; accesses are ignored |

## Verification
Both outputs are registered once after the access that causes them. The request and the disable therefore appear one edge after the sixth read is sampled, and the disable clears one edge after `store_done` is sampled. The bench drives inputs on the falling edge and advances a behavioural reference at each rising edge. It compares both outputs with the reference at the next falling edge, so every cycle is checked exactly where its result is due. Scenario-level checks also count request pulses after each access pattern has settled.

// File: rtl/swst_pkg.sv
package swst_pkg;

   localparam int SWST_SEQ_LEN = 6;

   // Unlock addresses in the order they must be read.
   function automatic logic [15:0] swst_seq_addr(input int idx);
      logic [15:0] a;
      case (idx)
         0:       a = 16'h0E38;
         1:       a = 16'h31C7;
         2:       a = 16'h03E0;
         3:       a = 16'h3C1F;
         4:       a = 16'h303F;
         default: a = 16'h0FC0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/swst_addr_match.sv
module swst_addr_match
   import swst_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int STEPS  = SWST_SEQ_LEN
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [STEPS-1:0]  hit
);

   // One comparator for each step of the sequence.
   for (genvar i = 0; i < STEPS; i++) begin : g_cmp
      localparam logic [ADDR_W-1:0] STEP_ADDR = ADDR_W'(swst_seq_addr(i));
      assign hit[i] = (addr == STEP_ADDR);
   end

endmodule

// File: rtl/swst_step_ctrl.sv
module swst_step_ctrl #(
   parameter int STEPS            = 6,
   parameter int CNT_W            = 3,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_fire,
   input  logic             acc_write,
   input  logic [STEPS-1:0] hit,
   output logic             trig
);

   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

   logic [CNT_W-1:0] step_q, step_d;
   logic             exp_hit;
   logic [CNT_W-1:0] abort_step;

   // Pick the comparator result for the step currently awaited.
   always_comb begin
      exp_hit = 1'b0;
      for (int i = 0; i < STEPS; i++) begin
         if (step_q == CNT_W'(i)) exp_hit = hit[i];
      end
   end

   // Where a broken read lands: at step two when it hits the first address.
   if (RESTART_ON_FIRST) begin : g_restart
      assign abort_step = hit[0] ? CNT_W'(1) : '0;
   end else begin : g_idle
      assign abort_step = '0;
   end

   assign trig = acc_fire && !acc_write && exp_hit && (step_q == LAST_STEP);

   always_comb begin
      step_d = step_q;
      if (acc_fire) begin
         if (acc_write)              step_d = '0;
         else if (!exp_hit)          step_d = abort_step;
         else if (step_q == LAST_STEP) step_d = '0;
         else                        step_d = step_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_q <= '0;
      else        step_q <= step_d;
   end

endmodule

// File: rtl/swst_req_busy.sv
module swst_req_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic store_done,
   output logic store_req,
   output logic io_disable
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_req  <= 1'b0;
         io_disable <= 1'b0;
      end else begin
         store_req <= trig;
         if (trig)                          io_disable <= 1'b1;
         else if (io_disable && store_done) io_disable <= 1'b0;
      end
   end

endmodule

// File: rtl/swst_seq_detect.sv
module swst_seq_detect
   import swst_pkg::*;
#(
   parameter int ADDR_W           = 15,
   parameter int STEPS            = SWST_SEQ_LEN,
   parameter bit RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              store_done,
   output logic              store_req,
   output logic              io_disable
);

   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

   if (ADDR_W < 14) begin : g_bad_addr_w
      $error("swst_seq_detect: ADDR_W must hold 14-bit unlock addresses");
   end
   if (STEPS != SWST_SEQ_LEN) begin : g_bad_steps
      $error("swst_seq_detect: STEPS must equal the unlock sequence length");
   end

   logic             acc_fire;
   logic [STEPS-1:0] hit;
   logic             trig;

   assign acc_fire = acc_valid && !io_disable;

   swst_addr_match #(.ADDR_W(ADDR_W), .STEPS(STEPS)) u_match (
      .addr (acc_addr),
      .hit  (hit)
   );

   swst_step_ctrl #(
      .STEPS(STEPS), .CNT_W(CNT_W), .RESTART_ON_FIRST(RESTART_ON_FIRST)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_fire  (acc_fire),
      .acc_write (acc_write),
      .hit       (hit),
      .trig      (trig)
   );

   swst_req_busy u_busy (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig),
      .store_done (store_done),
      .store_req  (store_req),
      .io_disable (io_disable)
   );

endmodule

// File: rtl/swst_chk.sv
module swst_chk (
   input logic clk,
   input logic rst_n,
   input logic store_done,
   input logic store_req,
   input logic io_disable
);

   // R3: a request never lasts two cycles
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |=> !store_req);

   // R7: the disable accompanies every request
   a_r7_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> io_disable);

   // R7: the disable only rises with a request
   a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_disable) |-> store_req);

   // R7: the disable holds until done is seen
   a_r7_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (io_disable && !store_done) |=> io_disable);

   // R7: done while busy clears the disable
   a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (io_disable && store_done) |=> !io_disable);

   // R8: no request can come from an access made while busy
   a_r8_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      io_disable |=> !store_req);

endmodule

bind swst_seq_detect swst_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .store_done (store_done),
   .store_req  (store_req),
   .io_disable (io_disable)
);

// File: tb/swst_seq_detect_tb.sv
module swst_seq_detect_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [14:0] acc_addr = '0;
   logic        store_done = 1'b0;
   logic        store_req;
   logic        io_disable;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   string tag = "R1";

   int seq_q[$] = '{32'h0E38, 32'h31C7, 32'h03E0, 32'h3C1F, 32'h303F, 32'h0FC0};

   // Reference model state
   int step = 0;
   bit exp_req = 0;
   bit exp_busy = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   swst_seq_detect u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .store_done(store_done),
      .store_req(store_req), .io_disable(io_disable)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step = 0; exp_req = 0; exp_busy = 0;
      end else begin
         bit nreq, nbusy;
         nreq = 0;
         nbusy = exp_busy;
         if (exp_busy && store_done) nbusy = 0;
         if (acc_valid && !exp_busy) begin
            if (acc_write) step = 0;
            else if (int'(acc_addr) == seq_q[step]) begin
               if (step == seq_q.size() - 1) begin
                  step = 0; nreq = 1; nbusy = 1;
               end else step++;
            end else if (int'(acc_addr) == seq_q[0]) step = 1;
            else step = 0;
         end
         exp_req = nreq;
         exp_busy = nbusy;
      end
   end

   // Cycle compare against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (store_req !== exp_req || io_disable !== exp_busy) begin
            failures++;
            $display("FAIL %s cycle compare: req=%0b busy=%0b expected req=%0b busy=%0b",
                     tag, store_req, io_disable, exp_req, exp_busy);
         end
         if (store_req) pulses++;
      end
   end

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic acc(bit w, int a);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_addr = 15'(a);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         acc_valid = 1'b0; acc_write = 1'b0; store_done = 1'b0;
      end
   endtask

   task automatic run_steps(int from, int upto);
      for (int i = from; i <= upto; i++) acc(1'b0, seq_q[i]);
   endtask

   task automatic done_pulse();
      @(negedge clk);
      acc_valid = 1'b0; store_done = 1'b1;
      @(negedge clk);
      store_done = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1", store_req, 0, "store_req after reset");
      check("R1", io_disable, 0, "io_disable after reset");
      p0 = pulses;
      run_steps(1, 5); idle(3);
      check("R1", pulses - p0, 0, "pulses from last five steps only");

      // R2 / R3 / R7 full sequence
      tag = "R2"; p0 = pulses;
      run_steps(0, 5);
      idle(1);                               // sixth read sampled; outputs now due
      check("R2", store_req, 1, "store_req after sixth read");
      check("R7", io_disable, 1, "io_disable with request");
      idle(1);
      check("R3", store_req, 0, "store_req one cycle later");
      idle(5);
      tag = "R7";
      check("R7", io_disable, 1, "io_disable held without done");
      check("R3", pulses - p0, 1, "single pulse per sequence");
      done_pulse();
      check("R7", io_disable, 0, "io_disable after done");

      // R4 wrong read aborts
      tag = "R4"; p0 = pulses;
      run_steps(0, 2); acc(1'b0, 32'h1234); run_steps(3, 5); idle(3);
      check("R4", pulses - p0, 0, "aborted by foreign read");

      // R5 write aborts even at the expected address
      tag = "R5"; p0 = pulses;
      run_steps(0, 1); acc(1'b1, seq_q[2]); run_steps(2, 5); idle(3);
      check("R5", pulses - p0, 0, "aborted by write");

      // R6 restart on the first address
      tag = "R6"; p0 = pulses;
      run_steps(0, 2); acc(1'b0, seq_q[0]); run_steps(1, 5); idle(3);
      check("R6", pulses - p0, 1, "restart after abort");
      done_pulse();
      p0 = pulses;
      acc(1'b0, seq_q[0]); run_steps(0, 5); idle(3);
      check("R6", pulses - p0, 1, "repeated first address");
      done_pulse();

      // R8 accesses ignored while busy
      tag = "R8"; p0 = pulses;
      run_steps(0, 5); idle(2);
      run_steps(0, 5); idle(3);
      check("R8", pulses - p0, 1, "sequence while busy ignored");
      check("R8", io_disable, 1, "still busy");
      run_steps(0, 2);
      done_pulse();
      run_steps(3, 5); idle(3);
      check("R8", pulses - p0, 1, "no progress kept from busy period");

      // R9 done while idle has no effect
      tag = "R9"; p0 = pulses;
      run_steps(0, 2); done_pulse();
      check("R9", io_disable, 0, "io_disable after idle done");
      run_steps(3, 5); idle(3);
      check("R9", pulses - p0, 1, "match survives idle done");
      done_pulse();

      // R10 idle gaps between steps
      tag = "R10"; p0 = pulses;
      for (int i = 0; i < 6; i++) begin
         acc(1'b0, seq_q[i]); idle(i + 1);
      end
      idle(2);
      check("R10", pulses - p0, 1, "sequence with gaps");
      done_pulse();
      idle(2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule